// File: doc/BRIEF.md
# Round-Robin Address-Polling Bus Arbiter

This block hands ownership of a shared bus to one of several masters without dedicated grant wires. Whenever any master raises its request, the controller starts broadcasting master indices on a narrow poll address bus, one index per clock. Every master compares the broadcast index with its own fixed index. When a master that is requesting sees its own index, it claims the bus, and the shared busy line rises on the next clock.

While busy is high the poll address holds still and no poll is marked valid. When the owner drops its request, busy falls. The next poll round starts at the index just after the last owner, so priority rotates and no master is favoured permanently. A master that never requests is passed over after one clock, so a dead or silent master cannot stall the arbiter. The per-master compare logic is part of this block, so the masters only present a request and watch their claim and ownership flags.

Top module: `poll_arbiter`

## Requirements
- R1: While reset is asserted and right after it, poll_valid is 0, busy is 0, poll_addr is 0 and no bit of mst_own is set.
- R2: When no poll is active and busy is 0, poll_valid rises on the clock after any bit of mst_req is sampled high. With no request it stays 0. The poll address bus is ceil(log2(N_MASTERS)) bits wide (3 bits for 8 masters).
- R3: While polling, if no requesting master matches and some request is still present, poll_addr increases by one on each clock and wraps from N_MASTERS-1 to 0.
- R4: When poll_valid is 1 and bit k of mst_req is 1 with k equal to poll_addr, mst_claim is the one-hot value with only bit k set in that same cycle. On the next clock busy is 1 and mst_own has only bit k set.
- R5: While busy is 1, poll_addr keeps the index of the owner and poll_valid is 0.
- R6: The owner keeps busy high for as long as its request stays high. One clock after its request is sampled low, busy and its mst_own bit return to 0.
- R7: On the clock after busy falls, poll_addr becomes the owner's index plus one, modulo N_MASTERS. If any request is present, poll_valid is 1 in that cycle. Otherwise that index is kept as the start point of the next round.
- R8: If every request is low while polling, poll_valid falls on the next clock and poll_addr holds. The next round starts from that held index.
- R9: A polled index whose master is not requesting produces no claim, and polling moves on to the next index one clock later.
- R10: At most one bit of mst_own and at most one bit of mst_claim is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_req | input | N_MASTERS | Request flag of each master; their OR forms the shared request |
| poll_valid | output | 1 | The poll address carries an index being polled |
| poll_addr | output | ADDR_W | Broadcast master index, ADDR_W = ceil(log2(N_MASTERS)) |
| busy | output | 1 | Shared busy line, high while some master owns the bus |
| mst_claim | output | N_MASTERS | Per-master match: requesting and addressed in this cycle |
| mst_own | output | N_MASTERS | Per-master ownership flag |

## Verification
The bench first runs a single request far from the reset index, so that the climb and the claim can be checked. It then runs a hand-off to a master below the previous owner, which forces a wrap and separates rotation from fixed priority. Next it withdraws the only request in the middle of a round, which tells "stop and hold" apart from "keep counting" and from "restart at zero". A long random phase follows, in which requests come and go and owners release at random. On every clock that phase is compared against a behavioural reference. It exposes errors in the skip timing, the release timing and the point where polling resumes.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_POLL = 2'd1,
    PS_HOLD = 2'd2
  } poll_state_e;

  function automatic int addr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/poll_sequencer.sv
module poll_sequencer
  import poll_arb_pkg::*;
#(
  parameter int N_MASTERS = 8,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_req,
  input  logic              any_claim,
  input  logic              busy,
  output logic              poll_valid,
  output logic [ADDR_W-1:0] poll_addr
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(N_MASTERS - 1);

  poll_state_e       state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, ptr_inc;
  logic              ptr_en;

  assign ptr_inc = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    ptr_en  = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        if (any_req) state_d = PS_POLL;
      end
      PS_POLL: begin
        if (any_claim) begin
          state_d = PS_HOLD;
        end else if (!any_req) begin
          state_d = PS_IDLE;
        end else begin
          ptr_d  = ptr_inc;
          ptr_en = 1'b1;
        end
      end
      PS_HOLD: begin
        if (!busy) begin
          ptr_d   = ptr_inc;
          ptr_en  = 1'b1;
          state_d = any_req ? PS_POLL : PS_IDLE;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign poll_valid = (state_q == PS_POLL);
  assign poll_addr  = ptr_q;

endmodule

// File: rtl/poll_master_tap.sv
module poll_master_tap #(
  parameter int ADDR_W = 3,
  parameter int TAP_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              poll_valid,
  input  logic [ADDR_W-1:0] poll_addr,
  output logic              claim,
  output logic              own
);

  localparam logic [ADDR_W-1:0] MY_IDX = ADDR_W'(TAP_ID);

  logic own_q, own_d, own_en;

  assign claim = poll_valid && (poll_addr == MY_IDX) && req;

  always_comb begin
    own_en = claim || own_q;
    own_d  = own_q ? req : claim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= 1'b0;
    end else if (own_en) begin
      own_q <= own_d;
    end
  end

  assign own = own_q;

endmodule

// File: rtl/poll_wire_or.sv
module poll_wire_or #(
  parameter int N_MASTERS = 8
) (
  input  logic [N_MASTERS-1:0] req_vec,
  input  logic [N_MASTERS-1:0] claim_vec,
  input  logic [N_MASTERS-1:0] own_vec,
  output logic                 any_req,
  output logic                 any_claim,
  output logic                 busy
);

  assign any_req   = |req_vec;
  assign any_claim = |claim_vec;
  assign busy      = |own_vec;

endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter
  import poll_arb_pkg::*;
#(
  parameter  int N_MASTERS = 8,
  localparam int ADDR_W    = addr_width(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] mst_req,
  output logic                 poll_valid,
  output logic [ADDR_W-1:0]    poll_addr,
  output logic                 busy,
  output logic [N_MASTERS-1:0] mst_claim,
  output logic [N_MASTERS-1:0] mst_own
);

  logic any_req;
  logic any_claim;

  poll_sequencer #(
    .N_MASTERS (N_MASTERS),
    .ADDR_W    (ADDR_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_req    (any_req),
    .any_claim  (any_claim),
    .busy       (busy),
    .poll_valid (poll_valid),
    .poll_addr  (poll_addr)
  );

  for (genvar k = 0; k < N_MASTERS; k++) begin : g_tap
    poll_master_tap #(
      .ADDR_W (ADDR_W),
      .TAP_ID (k)
    ) u_tap (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (mst_req[k]),
      .poll_valid (poll_valid),
      .poll_addr  (poll_addr),
      .claim      (mst_claim[k]),
      .own        (mst_own[k])
    );
  end

  poll_wire_or #(
    .N_MASTERS (N_MASTERS)
  ) u_or (
    .req_vec   (mst_req),
    .claim_vec (mst_claim),
    .own_vec   (mst_own),
    .any_req   (any_req),
    .any_claim (any_claim),
    .busy      (busy)
  );

endmodule

// File: rtl/poll_arbiter_chk.sv
module poll_arbiter_chk
  import poll_arb_pkg::*;
#(
  parameter  int N_MASTERS = 8,
  localparam int ADDR_W    = addr_width(N_MASTERS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] mst_req,
  input logic                 poll_valid,
  input logic [ADDR_W-1:0]    poll_addr,
  input logic                 busy,
  input logic [N_MASTERS-1:0] mst_claim,
  input logic [N_MASTERS-1:0] mst_own
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(N_MASTERS - 1);

  logic [ADDR_W-1:0] addr_after;
  assign addr_after = (poll_addr == LAST_IDX) ? '0 : poll_addr + 1'b1;

  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!poll_valid && !busy && |mst_req) |=> poll_valid); // R2

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_valid && mst_claim == '0 && |mst_req) |=> (poll_valid && poll_addr == $past(addr_after))); // R3

  AST_CLAIM_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|mst_claim) |=> (busy && mst_own == $past(mst_claim))); // R4

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(poll_addr) && !poll_valid)); // R5

  AST_OWNER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((mst_own & mst_req) != '0) |=> (busy && $stable(mst_own))); // R6

  AST_RESUME_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> (poll_addr == $past(addr_after))); // R7

  AST_STOP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req == '0) |=> !poll_valid); // R8

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(mst_own) && $onehot0(mst_claim))); // R10

endmodule

bind poll_arbiter poll_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mst_req    (mst_req),
  .poll_valid (poll_valid),
  .poll_addr  (poll_addr),
  .busy       (busy),
  .mst_claim  (mst_claim),
  .mst_own    (mst_own)
);

// File: tb/tb_poll_arbiter.sv
`timescale 1ns/100ps
module tb_poll_arbiter;

  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] mst_req;
  logic         poll_valid;
  logic [2:0]   poll_addr;
  logic         busy;
  logic [N-1:0] mst_claim;
  logic [N-1:0] mst_own;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 0;
  bit done   = 0;

  poll_arbiter #(.N_MASTERS(N)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mst_req    (mst_req),
    .poll_valid (poll_valid),
    .poll_addr  (poll_addr),
    .busy       (busy),
    .mst_claim  (mst_claim),
    .mst_own    (mst_own)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // behavioural reference: 0 idle, 1 polling, 2 owned/releasing
  int m_st, m_ptr, m_own;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_own = -1;
    end else begin
      case (m_st)
        0: if (mst_req != 0) m_st = 1;
        1: begin
          if (mst_req[m_ptr]) begin m_own = m_ptr; m_st = 2; end
          else if (mst_req == 0) m_st = 0;
          else m_ptr = (m_ptr + 1) % N;
        end
        default: begin
          if (m_own >= 0) begin
            if (!mst_req[m_own]) m_own = -1;
          end else begin
            m_ptr = (m_ptr + 1) % N;
            m_st  = (mst_req != 0) ? 1 : 0;
          end
        end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      int ev, ec, eo;
      ev = (m_st == 1);
      ec = (m_st == 1 && mst_req[m_ptr]) ? (1 << m_ptr) : 0;
      eo = (m_own >= 0) ? (1 << m_own) : 0;
      chk("R2 model poll_valid", int'(poll_valid), ev);
      chk("R3 model poll_addr", int'(poll_addr), m_ptr);
      chk("R4 model mst_claim", int'(mst_claim), ec);
      chk("R6 model busy", int'(busy), int'(m_own >= 0));
      chk("R10 model mst_own", int'(mst_own), eo);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(input logic [N-1:0] v);
    #1 mst_req = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    mst_req = '0;
    repeat (3) tick();
    chk("R1 reset poll_valid", int'(poll_valid), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset poll_addr", int'(poll_addr), 0);
    chk("R1 reset mst_own", int'(mst_own), 0);
    #1 rst_n = 1;
    cmp_en = 1;
    tick();
    chk("R1 after reset poll_valid", int'(poll_valid), 0);
    repeat (2) tick();
    chk("R2 no request keeps idle", int'(poll_valid), 0);

    // single request from master 5
    drive(8'h20);
    tick();
    chk("R2 start after request", int'(poll_valid), 1);
    for (int i = 0; i < 20 && !busy; i++) begin
      if (poll_valid && poll_addr < 5) chk("R9 silent index no claim", int'(mst_claim), 0);
      if (poll_valid && poll_addr == 5) chk("R4 claim one-hot", int'(mst_claim), 32'h20);
      tick();
    end
    chk("R4 owner flag", int'(mst_own), 32'h20);
    chk("R5 frozen addr", int'(poll_addr), 5);
    chk("R5 no valid while held", int'(poll_valid), 0);
    repeat (3) tick();
    chk("R6 busy held", int'(busy), 1);
    chk("R5 still frozen", int'(poll_addr), 5);

    // hand off to master 2 (below the owner): forces wrap
    drive(8'h04);
    tick();
    chk("R6 release busy", int'(busy), 0);
    chk("R6 release own", int'(mst_own), 0);
    tick();
    chk("R7 resume valid", int'(poll_valid), 1);
    chk("R7 resume after owner", int'(poll_addr), 6);
    chk("R9 skip silent 6", int'(mst_claim), 0);
    tick();
    chk("R3 step to 7", int'(poll_addr), 7);
    tick();
    chk("R3 wrap to 0", int'(poll_addr), 0);
    tick();
    chk("R3 step to 1", int'(poll_addr), 1);
    tick();
    chk("R4 claim master 2", int'(mst_claim), 32'h04);
    tick();
    chk("R4 owner master 2", int'(mst_own), 32'h04);

    // release with no requests: park resume point
    drive(8'h00);
    tick();
    chk("R6 busy cleared", int'(busy), 0);
    tick();
    chk("R7 idle after release", int'(poll_valid), 0);
    chk("R7 parked resume index", int'(poll_addr), 3);
    repeat (3) tick();
    chk("R2 idle holds", int'(poll_valid), 0);

    // withdraw mid-round
    drive(8'h01);
    tick();
    chk("R7 round starts at parked index", int'(poll_addr), 3);
    tick();
    chk("R3 step to 4", int'(poll_addr), 4);
    drive(8'h00);
    tick();
    chk("R8 stop valid", int'(poll_valid), 0);
    chk("R8 hold addr", int'(poll_addr), 4);
    drive(8'h01);
    tick();
    chk("R8 resume from held", int'(poll_addr), 4);
    chk("R8 resume valid", int'(poll_valid), 1);
    for (int i = 0; i < 20 && !busy; i++) tick();
    chk("R4 master 0 owns", int'(mst_own), 32'h01);
    drive(8'h00);
    repeat (3) tick();

    // random traffic compared against the reference every clock (R10)
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] nv;
      nv = mst_req;
      for (int k = 0; k < N; k++) begin
        if (mst_own[k]) begin
          if ($urandom_range(3) == 0) nv[k] = 1'b0;
        end else if (!nv[k]) begin
          if ($urandom_range(5) == 0) nv[k] = 1'b1;
        end else if ($urandom_range(15) == 0) begin
          nv[k] = 1'b0;
        end
      end
      if ($urandom_range(99) == 0) nv = '0;
      drive(nv);
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule